// File: doc/BRIEF.md
# Video Memory Transfer Engine

This block moves data into the video memories of a tile-based display controller without processor involvement. It has three modes. The first streams 16-bit words from an external bus into one of three video memories. The second copies bytes inside the 64 KiB pattern memory (VRAM). The third fills a run of VRAM bytes with a constant. Each mode finishes one transfer unit per clock cycle, and the destination address steps by a programmable stride after each unit.

A register front end, which is not part of this block, collects the transfer setup and arms the engine with a one-cycle start pulse. The setup is the mode, a 24-bit source, a 16-bit unit count, a 16-bit destination, an 8-bit stride, the target memory and a fill word. The engine then requests external reads and drives a two-lane byte write port into the video memories. It holds busy high until the count is used up. A global enable pauses the transfer at any point without losing its place.

Top module: `vmem_dma_engine`

## Requirements
- R1: After reset, busy, ext_req, wr_en_a and wr_en_b are all low.
- R2: A start pulse with mode 1, 2 or 3 and a nonzero count, seen while the engine is idle, latches the setup and raises busy in the next cycle. A start pulse seen while busy has no effect, and mode 0 is ignored.
- R3: While dma_en is low, no step happens: ext_req stays low, nothing is written, and the transfer resumes from the same place once dma_en returns high.
- R4: In mode 1 (bus transfer), ext_req is high with ext_addr equal to the current source while the engine is busy and enabled. A cycle with ext_ack high is one step. One cycle later, lane A writes ext_rdata[15:8] at the destination and lane B writes ext_rdata[7:0] at the destination plus one. Without ext_ack the engine stalls.
- R5: In mode 1, each step adds 2 to the source (modulo 2^24), adds the stride to the destination (modulo 2^16) and subtracts 1 from the count.
- R6: In mode 2 (copy), vram_raddr is the low 16 bits of the source. Each step writes vram_rdata to VRAM at the destination on lane A only, adds 1 to the source and adds the stride to the destination.
- R7: In mode 3 (fill), each step writes fill_word[7:0] to VRAM at the destination on lane A only. Only the destination advances, by the stride.
- R8: Write addresses are reduced modulo the size of the target memory: 65536 for VRAM (wr_mem 0), 128 for CRAM (wr_mem 1) and 80 for VSRAM (wr_mem 2). A target code of 3 acts as CRAM. Modes 2 and 3 always target VRAM.
- R9: The step that brings the count to zero also clears busy. That step's write appears in the cycle in which busy first reads low, and no write follows it.
- R10: A start with a count of zero leaves busy low and produces no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dma_en | input | 1 | Global enable; low pauses stepping |
| start | input | 1 | One-cycle arm pulse |
| mode | input | 2 | 0 none, 1 bus transfer, 2 copy, 3 fill |
| src_addr | input | 24 | Source address |
| xfer_count | input | 16 | Number of units |
| dst_addr | input | 16 | Destination address |
| stride | input | 8 | Destination step per unit |
| target | input | 2 | Mode-1 target: 0 VRAM, 1 CRAM, 2 VSRAM |
| fill_word | input | 16 | Fill value; low byte used |
| ext_req | output | 1 | External read request |
| ext_addr | output | 24 | External read address |
| ext_ack | input | 1 | Read data valid this cycle |
| ext_rdata | input | 16 | External read data |
| vram_raddr | output | 16 | VRAM read address for copy |
| vram_rdata | input | 8 | VRAM read data, same cycle |
| wr_en_a | output | 1 | Lane A write enable |
| wr_en_b | output | 1 | Lane B write enable |
| wr_mem | output | 2 | Memory written: 0 VRAM, 1 CRAM, 2 VSRAM |
| wr_addr_a | output | 16 | Lane A byte address |
| wr_addr_b | output | 16 | Lane B byte address |
| wr_data_a | output | 8 | Lane A byte |
| wr_data_b | output | 8 | Lane B byte |
| busy | output | 1 | Transfer in progress |

## Verification
The bench places destinations where they wrap. It uses 0xFFFC in VRAM, 0x7E in CRAM and 78 in VSRAM, so a design that reduced the address with the wrong modulus, or only once for both lanes, writes past the end of the small memories. Read acknowledges arrive in an irregular pattern, so an engine that stepped without ext_ack would drift from the expected source and data. The enable is dropped in the middle of a fill, a second start is issued while busy, and a start is given with a zero count. An engine that ignored the enable, re-armed, or underflowed its count would keep writing where none is expected.

// File: rtl/vmem_dma_engine.sv
module vmem_dma_engine #(
  parameter int SRC_W       = 24,
  parameter int CNT_W       = 16,
  parameter int DST_W       = 16,
  parameter int STEP_W      = 8,
  parameter int VRAM_BYTES  = 65536,
  parameter int CRAM_BYTES  = 128,
  parameter int VSRAM_BYTES = 80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dma_en,
  input  logic              start,
  input  logic [1:0]        mode,
  input  logic [SRC_W-1:0]  src_addr,
  input  logic [CNT_W-1:0]  xfer_count,
  input  logic [DST_W-1:0]  dst_addr,
  input  logic [STEP_W-1:0] stride,
  input  logic [1:0]        target,
  input  logic [15:0]       fill_word,
  output logic              ext_req,
  output logic [SRC_W-1:0]  ext_addr,
  input  logic              ext_ack,
  input  logic [15:0]       ext_rdata,
  output logic [DST_W-1:0]  vram_raddr,
  input  logic [7:0]        vram_rdata,
  output logic              wr_en_a,
  output logic              wr_en_b,
  output logic [1:0]        wr_mem,
  output logic [DST_W-1:0]  wr_addr_a,
  output logic [DST_W-1:0]  wr_addr_b,
  output logic [7:0]        wr_data_a,
  output logic [7:0]        wr_data_b,
  output logic              busy
);
  localparam logic [1:0] M_BUS = 2'd1, M_COPY = 2'd2, M_FILL = 2'd3;
  localparam logic [1:0] T_VRAM = 2'd0, T_VSRAM = 2'd2;

  logic [1:0]        mode_q, tgt_q;
  logic [SRC_W-1:0]  src_q;
  logic [DST_W-1:0]  dst_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [STEP_W-1:0] step_q;
  logic [7:0]        fill_q;
  logic              step;

  function automatic logic [DST_W-1:0] wrap(input logic [DST_W-1:0] a, input logic [1:0] t);
    case (t)
      T_VRAM:  wrap = DST_W'(32'(a) % VRAM_BYTES);
      T_VSRAM: wrap = DST_W'(32'(a) % VSRAM_BYTES);
      default: wrap = DST_W'(32'(a) % CRAM_BYTES);
    endcase
  endfunction

  assign step       = busy & dma_en & ((mode_q != M_BUS) | ext_ack);
  assign ext_req    = busy & dma_en & (mode_q == M_BUS);
  assign ext_addr   = src_q;
  assign vram_raddr = src_q[DST_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      wr_en_a <= 1'b0;
      wr_en_b <= 1'b0;
      mode_q  <= '0;
      tgt_q   <= '0;
      src_q   <= '0;
      dst_q   <= '0;
      cnt_q   <= '0;
      step_q  <= '0;
      fill_q  <= '0;
      wr_mem  <= '0;
      wr_addr_a <= '0;
      wr_addr_b <= '0;
      wr_data_a <= '0;
      wr_data_b <= '0;
    end else begin
      wr_en_a <= 1'b0;
      wr_en_b <= 1'b0;
      if (step) begin
        wr_en_a   <= 1'b1;
        wr_mem    <= tgt_q;
        wr_addr_a <= wrap(dst_q, tgt_q);
        wr_addr_b <= wrap(dst_q + 1'b1, tgt_q);
        dst_q     <= dst_q + DST_W'(step_q);
        cnt_q     <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) busy <= 1'b0;
        case (mode_q)
          M_BUS: begin
            wr_en_b   <= 1'b1;
            wr_data_a <= ext_rdata[15:8];
            wr_data_b <= ext_rdata[7:0];
            src_q     <= src_q + SRC_W'(2);
          end
          M_COPY: begin
            wr_data_a <= vram_rdata;
            src_q     <= src_q + SRC_W'(1);
          end
          default: wr_data_a <= fill_q;
        endcase
      end else if (!busy && start && mode != 2'd0 && xfer_count != '0) begin
        busy   <= 1'b1;
        mode_q <= mode;
        tgt_q  <= (mode == M_BUS) ? target : T_VRAM;
        src_q  <= src_addr;
        dst_q  <= dst_addr;
        cnt_q  <= xfer_count;
        step_q <= stride;
        fill_q <= fill_word[7:0];
      end
    end
  end

  a_r3_no_write_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_en |=> !wr_en_a);
  a_r4_req_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ext_req |-> busy);
  a_r4_lane_b_paired: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_b |-> wr_en_a);
  a_r8_vsram_range: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_a && wr_mem == T_VSRAM) |-> (32'(wr_addr_a) < VSRAM_BYTES && 32'(wr_addr_b) < VSRAM_BYTES));
  a_r8_cram_range: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_a && (wr_mem == 2'd1 || wr_mem == 2'd3)) |-> 32'(wr_addr_a) < CRAM_BYTES);
  a_r9_last_write_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> wr_en_a);
  a_r10_zero_count_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && xfer_count == '0) |=> !busy);
endmodule

// File: tb/vmem_dma_engine_test.sv
module vmem_dma_engine_test;
  logic clk = 0, rst_n = 0, dma_en = 1, start = 0, ext_ack = 0;
  logic [1:0] mode = 0, target = 0;
  logic [23:0] src_addr = 0;
  logic [15:0] xfer_count = 0, dst_addr = 0, fill_word = 0;
  logic [7:0] stride = 0;
  logic ext_req, wr_en_a, wr_en_b, busy;
  logic [23:0] ext_addr;
  logic [15:0] ext_rdata, vram_raddr, wr_addr_a, wr_addr_b;
  logic [7:0] vram_rdata, wr_data_a, wr_data_b;
  logic [1:0] wr_mem;

  int total = 0, bad = 0, cyc = 0, writes = 0;
  bit ack_on = 1, done = 0;

  vmem_dma_engine uut (.*);

  always #2 clk = ~clk;

  function automatic logic [15:0] ext_fn(input logic [23:0] a);
    return {a[7:0] ^ 8'hC3, a[15:8] + 8'h11};
  endfunction
  function automatic logic [7:0] vr_fn(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction
  assign ext_rdata  = ext_fn(ext_addr);
  assign vram_rdata = vr_fn(vram_raddr);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // behavioural reference model
  int m_busy = 0, m_mode = 0, m_tgt = 0, m_src = 0, m_dst = 0, m_cnt = 0, m_inc = 0, m_fill = 0;
  int e_wa = 0, e_wb = 0, e_mem = 0, e_aa = 0, e_ab = 0, e_da = 0, e_db = 0, e_kind = 0;

  function automatic int msize(input int t);
    return (t == 0) ? 65536 : (t == 2) ? 80 : 128;
  endfunction

  always @(posedge clk) begin
    e_wa = 0; e_wb = 0;
    if (!rst_n) m_busy = 0;
    else if (m_busy != 0) begin
      if (dma_en && (m_mode != 1 || ext_ack)) begin
        e_wa = 1; e_kind = m_mode; e_mem = m_tgt;
        e_aa = m_dst % msize(m_tgt);
        e_ab = ((m_dst + 1) & 'hFFFF) % msize(m_tgt);
        if (m_mode == 1) begin
          e_wb = 1;
          e_da = ext_fn(m_src[23:0]) >> 8;
          e_db = ext_fn(m_src[23:0]) & 'hFF;
          m_src = (m_src + 2) & 'hFFFFFF;
        end else if (m_mode == 2) begin
          e_da = vr_fn(m_src[15:0]);
          m_src = (m_src + 1) & 'hFFFFFF;
        end else e_da = m_fill;
        m_dst = (m_dst + m_inc) & 'hFFFF;
        m_cnt = m_cnt - 1;
        if (m_cnt == 0) m_busy = 0;
      end
    end else if (start && mode != 0 && xfer_count != 0) begin
      m_busy = 1; m_mode = mode; m_tgt = (mode == 1) ? target : 0;
      m_src = src_addr; m_dst = dst_addr; m_cnt = xfer_count;
      m_inc = stride; m_fill = fill_word[7:0];
    end
  end

  always @(posedge clk) begin
    #1;
    cyc++;
    if (rst_n) begin
      chk(busy == (m_busy != 0), "R2 R9 busy", busy, m_busy);
      chk(ext_req == (m_busy != 0 && dma_en && m_mode == 1), "R3 R4 ext_req", ext_req, 0);
      if (ext_req) chk(ext_addr == m_src, "R5 ext_addr", ext_addr, m_src);
      if (m_busy != 0 && m_mode == 2) chk(vram_raddr == m_src[15:0], "R6 vram_raddr", vram_raddr, m_src & 'hFFFF);
      chk(wr_en_a == e_wa, "R9 wr_en_a", wr_en_a, e_wa);
      chk(wr_en_b == e_wb, "R4 wr_en_b", wr_en_b, e_wb);
      if (wr_en_a) begin
        writes++;
        chk(wr_mem == e_mem, "R8 wr_mem", wr_mem, e_mem);
        chk(wr_addr_a == e_aa, "R8 wr_addr_a", wr_addr_a, e_aa);
        chk(wr_data_a == e_da, e_kind == 1 ? "R4 wr_data_a" : e_kind == 2 ? "R6 wr_data_a" : "R7 wr_data_a",
            wr_data_a, e_da);
        if (wr_en_b) begin
          chk(wr_addr_b == e_ab, "R8 wr_addr_b", wr_addr_b, e_ab);
          chk(wr_data_b == e_db, "R4 wr_data_b", wr_data_b, e_db);
        end
      end
    end
    if (cyc > 20000) begin
      chk(0, "watchdog", cyc, 20000);
      report();
    end
  end

  always @(negedge clk) ext_ack = ack_on && (cyc % 3 != 1) && (cyc % 7 != 3);

  task automatic arm(input int md, input int src, input int cnt, input int dst,
                     input int inc, input int tgt, input int fw);
    @(negedge clk);
    mode = md[1:0]; src_addr = src[23:0]; xfer_count = cnt[15:0]; dst_addr = dst[15:0];
    stride = inc[7:0]; target = tgt[1:0]; fill_word = fw[15:0]; start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic finish_run();
    for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int w0;
    repeat (3) @(negedge clk);
    chk(!busy && !ext_req && !wr_en_a && !wr_en_b, "R1 reset state", busy, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !wr_en_a, "R1 idle after reset", busy, 0);

    arm(1, 'h123456, 5, 'hFFFC, 2, 0, 0); finish_run();
    arm(1, 'hFFFFFE, 4, 'h7E, 1, 1, 0); finish_run();
    arm(1, 'h000100, 3, 78, 2, 2, 0); finish_run();
    arm(1, 'h000200, 3, 'h7F, 1, 3, 0); finish_run();
    arm(2, 'hFFFE, 6, 'h0100, 3, 2, 0); finish_run();
    arm(2, 'h4000, 4, 'h10, 0, 0, 0); finish_run();

    // enable dropped mid-fill
    arm(3, 0, 6, 10, 'h80, 1, 'hABCD);
    @(negedge clk);
    dma_en = 0;
    @(negedge clk);
    w0 = writes;
    repeat (5) @(negedge clk);
    chk(writes == w0, "R3 no writes while disabled", writes, w0);
    chk(busy == 1, "R3 busy held while disabled", busy, 1);
    dma_en = 1;
    finish_run();

    // start while busy ignored
    arm(2, 'h0500, 5, 'h2000, 1, 0, 0);
    arm(3, 0, 9, 'h3000, 1, 0, 'h55);
    finish_run();

    // mode 0 ignored
    w0 = writes;
    arm(0, 0, 4, 0, 1, 0, 0);
    repeat (2) @(negedge clk);
    chk(!busy && writes == w0, "R2 mode zero ignored", writes, w0);

    // zero count
    w0 = writes;
    arm(1, 'h10, 0, 0, 2, 0, 0);
    repeat (3) @(negedge clk);
    chk(!busy && writes == w0, "R10 zero count no writes", writes, w0);

    // stall without ack
    ack_on = 0;
    arm(1, 'h800, 2, 0, 2, 0, 0);
    w0 = writes;
    repeat (6) @(negedge clk);
    chk(writes == w0 && busy, "R4 stall without ack", writes, w0);
    ack_on = 1;
    finish_run();

    report();
  end
endmodule